// File: doc/BRIEF.md
# Message-Signaled Interrupt File

The block keeps, for a small set of interrupt pages (one supervisor page and one or more guest pages), a pending bit and an enable bit for every interrupt identity. Devices raise interrupts by writing a 32-bit word into a memory-mapped window. The address picks the page and the written value names the identity to mark pending. Each page continuously selects its top identity: the lowest-numbered one that is pending, enabled and allowed by the page's threshold. Each page drives one interrupt line toward the hart, gated by a per-page delivery bit.

Software reaches each page through a narrow register port. The port carries a page index, a register selector, a write strobe and write data, and returns read data in the same cycle. Through it software sets the delivery bit and the threshold, reads and writes whole words of pending and enable bits, and reads the top identity. Any write to the top-identity register claims that identity, which clears its pending bit. Privilege checks on who may use the register port belong to the surrounding logic.

Top module: `msi_intr_file`

## Requirements
- R1: After reset every pending bit, enable bit, delivery bit and threshold is zero, every irq_out line is low and every register reads zero.
- R2: Identity 0 is not implemented: bit 0 of pending word 0 and enable word 0 always reads 0 and ignores writes. The top identity is the lowest-numbered identity from 1 upward that is both pending and enabled.
- R3: When the threshold T satisfies 0 < T <= NUM_IDS, only identities strictly below T are eligible. Otherwise every implemented identity is eligible.
- R4: Selector 0x02 reads the top identity as (id << 16) | id, and reads 0 when no identity is eligible.
- R5: A write to selector 0x02 ignores its data and clears only the pending bit of the identity that was on top in that cycle. Other bits are unchanged. With nothing on top the write has no effect.
- R6: Selector 0x00 is the delivery register, and only its bit 0 is stored (reads as 0 or 1). irq_out[p] is high exactly when page p has delivery set and a nonzero top identity.
- R7: Selector 0x01 is the threshold, and it keeps only write-data bits [10:0]. The higher bits read as 0.
- R8: An MMIO write sets a pending bit only when all of the following hold: mmio_addr[11:0] is 0, the page index mmio_addr[31:12] is below NUM_PAGES, and the value satisfies 0 < value < NUM_IDS. The bit set is identity = value in page mmio_addr[31:12]. Any other MMIO write changes nothing.
- R9: Selector 0x40+k reads and writes pending identities 32k..32k+31 (bit b is identity 32k+b). Selector 0x80+k does the same for enables, for k below NUM_IDS/32. Other selectors, and page indices at or above NUM_PAGES, read 0 and ignore writes.
- R10: When a register write and a valid MMIO write affect the same pending bit in one cycle, the MMIO set wins and the bit ends up pending.
- R11: Register and MMIO writes take effect at the next rising clock edge. Read data and irq_out follow the stored state combinationally.

Parameters: NUM_PAGES (default 3), NUM_IDS (identity count including the absent identity 0, a multiple of 32, default 64). PG_W is derived from NUM_PAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mmio_we | input | 1 | MMIO write strobe |
| mmio_addr | input | 32 | MMIO byte offset within the window |
| mmio_wdata | input | 32 | MMIO write value (identity to raise) |
| reg_page | input | PG_W | Page addressed by the register port |
| reg_sel | input | 8 | Register selector |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | NUM_PAGES | Interrupt line per page |

## Verification
Two situations are hardest to reach from the ports. The first is a claim that lands while a second identity is pending behind the first: the claim must drop only the winner and let the next identity surface. The stimulus builds this by raising two identities in one page and then writing the top-identity register with junk data. The second is a register clear of a pending word in the same cycle as an MMIO set to that word. This is driven directly, and then repeated many times by a seeded stream of mixed operations on all pages, including misaligned, out-of-range and zero-valued MMIO writes. The reference model is compared against read data and every interrupt line on each clock.

// File: rtl/msi_pkg.sv
// Package: shared constants for the message-signaled interrupt file.
// Assumes an 8-bit register selector. The upper two selector bits pick a
// word group and the lower six bits pick the word inside the group.
package msi_pkg;
    localparam logic [7:0] SEL_DELIV  = 8'h00;
    localparam logic [7:0] SEL_THRESH = 8'h01;
    localparam logic [7:0] SEL_TOP    = 8'h02;
    localparam logic [1:0] GRP_PEND   = 2'b01;
    localparam logic [1:0] GRP_ENAB   = 2'b10;
    localparam int         THR_W      = 11;
    localparam int         PAGE_SHIFT = 12;
endpackage

// File: rtl/msi_prio_pick.sv
// Module: lowest-number priority pick for one page.
// Takes the pending and enable vectors and the threshold. Returns the lowest
// identity >= 1 that is pending, enabled and below the effective limit, or 0.
// Assumes NUM_IDS fits in 32 bits.
module msi_prio_pick #(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = $clog2(NUM_IDS),
    parameter int THR_W   = 11
) (
    input  logic [NUM_IDS-1:0] pend,
    input  logic [NUM_IDS-1:0] en,
    input  logic [THR_W-1:0]   thr,
    output logic [ID_W-1:0]    top_id
);
    int limit;

    // Effective limit: a nonzero threshold within range narrows eligibility.
    always_comb begin
        if (thr != '0 && 32'(thr) <= NUM_IDS) limit = 32'(thr);
        else                                  limit = NUM_IDS;
    end

    // Scan from the top down so the lowest eligible identity is kept last.
    always_comb begin
        top_id = '0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (pend[i] && en[i] && i < limit) top_id = ID_W'(i);
        end
    end
endmodule

// File: rtl/msi_write_decode.sv
// Module: MMIO write decoder.
// Qualifies an incoming 32-bit write: the page offset must be zero, the page
// index must be implemented and the value must be a real identity. Produces a
// one-hot page hit vector and the identity to set.
module msi_write_decode #(
    parameter int NUM_PAGES = 3,
    parameter int NUM_IDS   = 64,
    parameter int ID_W      = $clog2(NUM_IDS)
) (
    input  logic                 mmio_we,
    input  logic [31:0]          mmio_addr,
    input  logic [31:0]          mmio_wdata,
    output logic [NUM_PAGES-1:0] set_hit,
    output logic [ID_W-1:0]      set_id
);
    import msi_pkg::*;

    logic        ok;
    logic [31:0] pg;

    // Check alignment, page range and identity range of the write.
    always_comb begin
        pg = mmio_addr >> PAGE_SHIFT;
        ok = mmio_we
          && mmio_addr[PAGE_SHIFT-1:0] == '0
          && pg < 32'(NUM_PAGES)
          && mmio_wdata != '0
          && mmio_wdata < 32'(NUM_IDS);
    end

    // Fan the qualified write out to exactly one page.
    always_comb begin
        for (int p = 0; p < NUM_PAGES; p++) set_hit[p] = ok && pg == 32'(p);
    end

    assign set_id = mmio_wdata[ID_W-1:0];
endmodule

// File: rtl/msi_page.sv
// Module: one interrupt page.
// Holds the pending and enable bits, the delivery bit and the threshold. It
// serves register reads and writes, including the claim through the top
// register, and drives the page interrupt line. Register writes are applied
// first, then the MMIO set, so the set wins on the same bit.
module msi_page #(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = $clog2(NUM_IDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_set,
    input  logic [ID_W-1:0]    msi_id,
    input  logic               reg_hit,
    input  logic               reg_we,
    input  logic [7:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        rdata,
    output logic               irq,
    output logic [NUM_IDS-1:0] pend_q
);
    import msi_pkg::*;

    localparam int NUM_WORDS = NUM_IDS / 32;

    logic [NUM_IDS-1:0] en_q, pend_nx, en_nx;
    logic               deliv_q, deliv_nx;
    logic [THR_W-1:0]   thr_q, thr_nx;
    logic [ID_W-1:0]    top_id;
    logic [31:0]        top_w;
    logic               is_pend, is_enab;
    int                 widx;

    msi_prio_pick #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .THR_W(THR_W)) u_pick (
        .pend   (pend_q),
        .en     (en_q),
        .thr    (thr_q),
        .top_id (top_id)
    );

    // Decode the word groups of the selector.
    always_comb begin
        widx    = 32'(reg_sel[5:0]);
        is_pend = reg_sel[7:6] == GRP_PEND && widx < NUM_WORDS;
        is_enab = reg_sel[7:6] == GRP_ENAB && widx < NUM_WORDS;
        top_w   = 32'(top_id);
    end

    // Read mux for this page.
    always_comb begin
        rdata = '0;
        if (reg_hit) begin
            case (reg_sel)
                SEL_DELIV:  rdata = {31'b0, deliv_q};
                SEL_THRESH: rdata = 32'(thr_q);
                SEL_TOP:    rdata = (top_w << 16) | top_w;
                default: begin
                    if (is_pend)      rdata = pend_q[widx*32 +: 32];
                    else if (is_enab) rdata = en_q[widx*32 +: 32];
                end
            endcase
        end
    end

    // Next state: register write first, then MMIO set; identity 0 stays clear.
    always_comb begin
        pend_nx  = pend_q;
        en_nx    = en_q;
        deliv_nx = deliv_q;
        thr_nx   = thr_q;
        if (reg_hit && reg_we) begin
            case (reg_sel)
                SEL_DELIV:  deliv_nx = reg_wdata[0];
                SEL_THRESH: thr_nx   = reg_wdata[THR_W-1:0];
                SEL_TOP:    if (top_id != '0) pend_nx[top_id] = 1'b0;
                default: begin
                    if (is_pend)      pend_nx[widx*32 +: 32] = reg_wdata;
                    else if (is_enab) en_nx[widx*32 +: 32]   = reg_wdata;
                end
            endcase
        end
        if (msi_set) pend_nx[msi_id] = 1'b1;
        pend_nx[0] = 1'b0;
        en_nx[0]   = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            en_q    <= '0;
            deliv_q <= 1'b0;
            thr_q   <= '0;
        end else begin
            pend_q  <= pend_nx;
            en_q    <= en_nx;
            deliv_q <= deliv_nx;
            thr_q   <= thr_nx;
        end
    end

    assign irq = deliv_q && top_id != '0;
endmodule

// File: rtl/msi_intr_file.sv
// Module: message-signaled interrupt file, top level.
// Decodes MMIO writes into per-page pending sets. Instantiates one page per
// NUM_PAGES and routes the register port to the addressed page. Assumes
// NUM_IDS is a multiple of 32 and at most 2048.
module msi_intr_file #(
    parameter int NUM_PAGES = 3,
    parameter int NUM_IDS   = 64,
    parameter int PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mmio_we,
    input  logic [31:0]          mmio_addr,
    input  logic [31:0]          mmio_wdata,
    input  logic [PG_W-1:0]      reg_page,
    input  logic [7:0]           reg_sel,
    input  logic                 reg_we,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_PAGES-1:0] irq_out
);
    localparam int ID_W = $clog2(NUM_IDS);

    logic [NUM_PAGES-1:0]         set_hit;
    logic [ID_W-1:0]              set_id;
    logic [31:0]                  page_rd [NUM_PAGES];
    logic [NUM_PAGES*NUM_IDS-1:0] pend_flat;

    msi_write_decode #(.NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_dec (
        .mmio_we    (mmio_we),
        .mmio_addr  (mmio_addr),
        .mmio_wdata (mmio_wdata),
        .set_hit    (set_hit),
        .set_id     (set_id)
    );

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        msi_page #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_page (
            .clk       (clk),
            .rst_n     (rst_n),
            .msi_set   (set_hit[p]),
            .msi_id    (set_id),
            .reg_hit   (32'(reg_page) == p),
            .reg_we    (reg_we),
            .reg_sel   (reg_sel),
            .reg_wdata (reg_wdata),
            .rdata     (page_rd[p]),
            .irq       (irq_out[p]),
            .pend_q    (pend_flat[p*NUM_IDS +: NUM_IDS])
        );
    end

    // Return the read data of the addressed page, zero for absent pages.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (32'(reg_page) == p) reg_rdata = page_rd[p];
        end
    end
endmodule

// File: rtl/msi_intr_file_chk.sv
// Module: assertion checker for the interrupt file, bound to the top level.
// Watches the register port, the MMIO write port, the interrupt lines and the
// flattened pending state of all pages.
module msi_intr_file_chk #(
    parameter int NUM_PAGES = 3,
    parameter int NUM_IDS   = 64,
    parameter int PG_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mmio_we,
    input  logic [31:0]                  mmio_wdata,
    input  logic [PG_W-1:0]              reg_page,
    input  logic [7:0]                   reg_sel,
    input  logic                         reg_we,
    input  logic [31:0]                  reg_rdata,
    input  logic [NUM_PAGES-1:0]         irq_out,
    input  logic [NUM_PAGES*NUM_IDS-1:0] pend_flat
);
    logic page_ok, claim_q;
    int   claim_idx_q;

    assign page_ok = 32'(reg_page) < NUM_PAGES;

    // Remember a claim so the next cycle can check that its bit dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_q     <= 1'b0;
            claim_idx_q <= 0;
        end else begin
            claim_q     <= reg_we && reg_sel == 8'h02 && page_ok && reg_rdata != '0 && !mmio_we;
            claim_idx_q <= 32'(reg_page) * NUM_IDS + 32'(reg_rdata[15:0]);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> irq_out == '0); // R1

    AST_ID0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 8'h40 || reg_sel == 8'h80) |-> !reg_rdata[0]); // R2

    AST_TOP_TWO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == 8'h02 |-> (reg_rdata[31:16] == reg_rdata[15:0] && reg_rdata[15:11] == '0)); // R4

    AST_CLAIM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        claim_q |-> !pend_flat[claim_idx_q]); // R5

    AST_IRQ_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 8'h02 && page_ok && reg_rdata == '0) |-> !irq_out[reg_page]); // R6

    AST_BAD_MSI_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_we && mmio_wdata == '0 && !reg_we) |=> pend_flat == $past(pend_flat)); // R8
endmodule

bind msi_intr_file msi_intr_file_chk #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_IDS   (NUM_IDS),
    .PG_W      (PG_W)
) u_chk (.*);

// File: tb/sim_msi_intr_file.sv
`timescale 1ns/1ps
module sim_msi_intr_file;
    localparam int NP = 3;
    localparam int NI = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmio_we = 1'b0;
    logic [31:0] mmio_addr = '0;
    logic [31:0] mmio_wdata = '0;
    logic [1:0]  reg_page = '0;
    logic [7:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] irq_out;

    int checks = 0;
    int fails  = 0;

    bit mp [NP][NI];
    bit me [NP][NI];
    bit md [NP];
    int mt [NP];

    always #10 clk = ~clk;

    msi_intr_file #(.NUM_PAGES(NP), .NUM_IDS(NI)) u0 (
        .clk(clk), .rst_n(rst_n), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
        .mmio_wdata(mmio_wdata), .reg_page(reg_page), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mtop(input int p);
        int lim;
        lim = (mt[p] != 0 && mt[p] <= NI) ? mt[p] : NI;
        for (int i = 1; i < NI; i++) if (mp[p][i] && me[p][i] && i < lim) return i;
        return 0;
    endfunction

    function automatic logic [31:0] mread(input int p, input logic [7:0] s);
        logic [31:0] v;
        int w;
        v = '0;
        w = int'(s[5:0]);
        if (p >= NP) return '0;
        if (s == 8'h00) v = {31'b0, md[p]};
        else if (s == 8'h01) v = mt[p];
        else if (s == 8'h02) v = (mtop(p) << 16) | mtop(p);
        else if (s[7:6] == 2'b01 && w < NI/32) begin
            for (int b = 0; b < 32; b++) v[b] = mp[p][w*32+b];
        end else if (s[7:6] == 2'b10 && w < NI/32) begin
            for (int b = 0; b < 32; b++) v[b] = me[p][w*32+b];
        end
        return v;
    endfunction

    function automatic logic [NP-1:0] mirq();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = md[p] && mtop(p) != 0;
        return v;
    endfunction

    // One clock: drive, compare combinational read, advance model, compare lines.
    task automatic cyc(input string tag, input logic we, input logic [7:0] s,
                       input logic [1:0] pg, input logic [31:0] wd,
                       input logic mw, input logic [31:0] ma, input logic [31:0] mv);
        int p, w, t;
        reg_we = we; reg_sel = s; reg_page = pg; reg_wdata = wd;
        mmio_we = mw; mmio_addr = ma; mmio_wdata = mv;
        #1;
        chk(tag, reg_rdata, mread(int'(pg), s));
        p = int'(pg);
        w = int'(s[5:0]);
        if (we && p < NP) begin
            if (s == 8'h00) md[p] = wd[0];
            else if (s == 8'h01) mt[p] = int'(wd & 32'h7FF);
            else if (s == 8'h02) begin
                t = mtop(p);
                if (t != 0) mp[p][t] = 1'b0;
            end else if (s[7:6] == 2'b01 && w < NI/32) begin
                for (int b = 0; b < 32; b++) mp[p][w*32+b] = wd[b];
            end else if (s[7:6] == 2'b10 && w < NI/32) begin
                for (int b = 0; b < 32; b++) me[p][w*32+b] = wd[b];
            end
            mp[p][0] = 1'b0;
            me[p][0] = 1'b0;
        end
        if (mw && ma[11:0] == 0 && (ma >> 12) < NP && mv != 0 && mv < NI)
            mp[int'(ma >> 12)][int'(mv)] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 irq_out", 32'(irq_out), 32'(mirq()));
    endtask

    task automatic rd(input string tag, input logic [1:0] pg, input logic [7:0] s);
        cyc(tag, 1'b0, s, pg, '0, 1'b0, '0, '0);
    endtask

    task automatic wr(input string tag, input logic [1:0] pg, input logic [7:0] s, input logic [31:0] d);
        cyc(tag, 1'b1, s, pg, d, 1'b0, '0, '0);
    endtask

    task automatic msi(input string tag, input logic [31:0] a, input logic [31:0] v);
        cyc(tag, 1'b0, 8'h00, 2'd0, '0, 1'b1, a, v);
    endtask

    // Direct check of a read value against a constant expected from the requirements.
    task automatic expect_rd(input string tag, input logic [1:0] pg, input logic [7:0] s, input logic [31:0] e);
        reg_we = 1'b0; reg_sel = s; reg_page = pg; mmio_we = 1'b0;
        #1;
        chk(tag, reg_rdata, e);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        logic [7:0] sels [7];
        sels = '{8'h00, 8'h01, 8'h02, 8'h40, 8'h41, 8'h80, 8'h81};
        seed = 7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq after reset", 32'(irq_out), 32'h0);
        expect_rd("R1 top after reset", 2'd0, 8'h02, 32'h0);
        expect_rd("R1 pend after reset", 2'd2, 8'h41, 32'h0);
        expect_rd("R1 thresh after reset", 2'd1, 8'h01, 32'h0);

        // R2 / R9: enable word, identity 0 bit stays clear
        wr("R9 enab write", 2'd0, 8'h80, 32'hFFFF_FFFF);
        expect_rd("R2 enab bit0 zero", 2'd0, 8'h80, 32'hFFFF_FFFE);
        wr("R2 pend bit0 write", 2'd0, 8'h40, 32'h0000_0001);
        expect_rd("R2 pend bit0 ignored", 2'd0, 8'h40, 32'h0);

        // R8 / R6: raise 5 and 3 with delivery off
        msi("R8 msi id5", 32'h0, 32'd5);
        msi("R8 msi id3", 32'h0, 32'd3);
        chk("R6 no delivery", 32'(irq_out), 32'h0);
        expect_rd("R4 top format", 2'd0, 8'h02, 32'h0003_0003);
        wr("R6 delivery on", 2'd0, 8'h00, 32'hFFFF_FFFF);
        expect_rd("R6 delivery bit0 only", 2'd0, 8'h00, 32'h1);
        chk("R6 irq up", 32'(irq_out), 32'h1);

        // R3 / R7: threshold rules
        wr("R3 thr3", 2'd0, 8'h01, 32'd3);
        expect_rd("R3 thr3 excludes id3", 2'd0, 8'h02, 32'h0);
        chk("R3 irq low under thr", 32'(irq_out), 32'h0);
        wr("R3 thr4", 2'd0, 8'h01, 32'd4);
        expect_rd("R3 thr4 admits id3", 2'd0, 8'h02, 32'h0003_0003);
        wr("R3 thr65", 2'd0, 8'h01, 32'd65);
        expect_rd("R3 thr above count", 2'd0, 8'h02, 32'h0003_0003);
        wr("R7 thr mask", 2'd0, 8'h01, 32'hFFFF_F805);
        expect_rd("R7 thr keeps 11 bits", 2'd0, 8'h01, 32'h0000_0005);
        wr("R3 thr off", 2'd0, 8'h01, 32'd0);

        // R5: claim drops only the top identity
        wr("R5 claim", 2'd0, 8'h02, 32'h0000_1234);
        expect_rd("R5 next top", 2'd0, 8'h02, 32'h0005_0005);
        expect_rd("R5 pend after claim", 2'd0, 8'h40, 32'h0000_0020);

        // R8: rejected writes
        msi("R8 misaligned", 32'h2, 32'd9);
        msi("R8 nonzero offset", 32'h4, 32'd9);
        msi("R8 zero value", 32'h0, 32'd0);
        msi("R8 value at count", 32'h0, 32'd64);
        msi("R8 page out of range", 32'h3000, 32'd9);
        expect_rd("R8 nothing raised", 2'd0, 8'h40, 32'h0000_0020);
        expect_rd("R8 high word clear", 2'd0, 8'h41, 32'h0);

        // R8 / R9: page 2, identity 40 lands in word 1 bit 8
        msi("R8 page2 id40", 32'h2000, 32'd40);
        expect_rd("R9 page2 word1", 2'd2, 8'h41, 32'h0000_0100);
        expect_rd("R9 page1 untouched", 2'd1, 8'h41, 32'h0);
        wr("R9 page2 enab", 2'd2, 8'h81, 32'h0000_0100);
        wr("R6 page2 deliv", 2'd2, 8'h00, 32'h1);
        chk("R6 page2 line", 32'(irq_out), 32'h5);
        expect_rd("R9 bad selector", 2'd0, 8'h3F, 32'h0);
        wr("R9 bad page write", 2'd3, 8'h00, 32'h1);
        expect_rd("R9 bad page read", 2'd3, 8'h00, 32'h0);

        // R10: same-cycle clear and set
        cyc("R10 clear and set", 1'b1, 8'h40, 2'd0, 32'h0, 1'b1, 32'h0, 32'd7);
        expect_rd("R10 set wins", 2'd0, 8'h40, 32'h0000_0080);

        // R11: seeded mixed traffic compared against the model every clock
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            logic [31:0] a;
            r = $urandom(seed + n);
            a = {18'b0, 2'(r[25:24] % 4), 12'(r[26] ? 12'h0 : 12'(r[27:26]))};
            cyc("R11 mixed traffic", r[0] & r[1], sels[r[4:2] % 7], 2'(r[6:5]),
                (r[4:2] % 7 == 1) ? (r[31:24] % 70) : (r ^ 32'h5A5A_5A5A),
                r[7], a, 32'(r[15:8] % 70));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule